// File: doc/BRIEF.md
# SPI Master Byte Queue Front-End with Watermark Interrupts

This block sits between a processor's memory-mapped bus and the serial shifter of an SPI master. It holds two byte queues. The transmit queue is filled by bus writes and drained by the shifter. The receive queue is filled by the shifter and drained by bus reads. Software checks queue status without a separate status register: the full or empty flag is carried in bit 31 of the word that the data register returns.

Each queue has a programmable occupancy threshold. The block derives one level-sensitive pending bit from each threshold on every cycle. An enable mask gates the two pending bits onto a single interrupt line. A driver can therefore queue n bytes, set the receive threshold to n−1, and wait for the receive pending bit, which asserts once all n bytes have arrived.

Bus access is handled by a two-state machine. `ACC_IDLE` means no read reply is in flight. `ACC_REPLY` means the read data latched at the previous clock edge is valid on `bus_rdata`. Any read request moves the machine to `ACC_REPLY`, from either state. A cycle with no read request returns it to `ACC_IDLE`. Writes take effect at the clock edge that samples them and produce no reply.

Top module: `spi_fifo_if`

## Requirements
- R1: A bus write to address 0x48 pushes `bus_wdata[7:0]` into the transmit queue when the queue is not full. The shifter receives the bytes in the order they were written.
- R2: A bus write to 0x48 while the transmit queue holds DEPTH bytes is discarded. The queue contents and the occupancy are unchanged.
- R3: A bus read of 0x48 returns bit 31 = 1 when the transmit queue is full and 0 otherwise. All other bits read 0.
- R4: A bus read of 0x4C on a non-empty receive queue returns the oldest byte in bits 7:0 with bit 31 = 0, and removes that byte from the queue.
- R5: A bus read of 0x4C on an empty receive queue returns 0x8000_0000 and removes nothing.
- R6: `rx_push_ready` is low while the receive queue holds DEPTH bytes. A byte offered by the shifter in that state is not stored.
- R7: Bit 0 of the pending word (read at 0x74) is 1 exactly while transmit occupancy is strictly below the transmit threshold (0x50, read/write).
- R8: Bit 1 of the pending word is 1 exactly while receive occupancy is strictly above the receive threshold (0x54, read/write).
- R9: `irq` is high exactly when some bit of the enable mask (0x70, bits 1:0, read/write) and the same bit of the pending word are both 1.
- R10: A read request sampled at a clock edge yields `bus_rvalid` = 1 during the following cycle, with its data on `bus_rdata`. Threshold and enable registers read back the value last written.
- R11: After reset both queues are empty, thresholds and enables are 0, `tx_pop_valid`, `irq` and `bus_rvalid` are 0, and `rx_push_ready` is 1.
- R12: `tx_pop_valid` is high whenever the transmit queue is non-empty, and `tx_pop_data` shows the oldest byte. A cycle with `tx_pop_ready` high removes that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus request valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rvalid |
| bus_rvalid | output | 1 | Read reply valid |
| tx_pop_valid | output | 1 | Transmit queue has a byte for the shifter |
| tx_pop_data | output | 8 | Oldest transmit byte |
| tx_pop_ready | input | 1 | Shifter takes the byte |
| rx_push_valid | input | 1 | Shifter offers a received byte |
| rx_push_data | input | 8 | Received byte |
| rx_push_ready | output | 1 | Receive queue has room |
| irq | output | 1 | Masked watermark interrupt |

## Verification
The threshold comparisons are tested with occupancy below, equal to and above each threshold. An off-by-one in either strict comparison therefore changes a pending bit that is read back. The data paths are driven with distinct byte values across a full wrap of each queue, which exposes ordering faults and pointer-wrap faults. An overfilled queue and an empty receive read are each followed by a drain. The drain shows whether a dropped write, a refused push or a phantom pop changed the contents. The interrupt is checked with the mask both set and cleared over the same pending state, which separates masking faults from comparison faults.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
    localparam logic [7:0] ADDR_TXQ     = 8'h48;
    localparam logic [7:0] ADDR_RXQ     = 8'h4C;
    localparam logic [7:0] ADDR_TXLVL   = 8'h50;
    localparam logic [7:0] ADDR_RXLVL   = 8'h54;
    localparam logic [7:0] ADDR_IRQEN   = 8'h70;
    localparam logic [7:0] ADDR_IRQPEND = 8'h74;
    localparam int FLAG_BIT = 31;
    localparam int PEND_TX  = 0;
    localparam int PEND_RX  = 1;
    localparam int NPEND    = 2;
    typedef enum logic {ACC_IDLE, ACC_REPLY} acc_state_e;
endpackage

// File: rtl/spi_fifo_buf.sv
module spi_fifo_buf #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_en,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop_en,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push_en && !full;
    assign do_pop  = pop_en && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end
endmodule

// File: rtl/spi_fifo_wm.sv
module spi_fifo_wm
    import spi_fifo_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic [CW-1:0]    tx_count,
    input  logic [CW-1:0]    rx_count,
    input  logic [CW-1:0]    tx_mark,
    input  logic [CW-1:0]    rx_mark,
    input  logic [NPEND-1:0] irq_en,
    output logic [NPEND-1:0] pend,
    output logic             irq
);
    always_comb begin
        pend          = '0;
        pend[PEND_TX] = (tx_count < tx_mark);
        pend[PEND_RX] = (rx_count > rx_mark);
        irq           = |(pend & irq_en);
    end
endmodule

// File: rtl/spi_fifo_regs.sv
module spi_fifo_regs
    import spi_fifo_pkg::*;
#(
    parameter int CW = 4,
    parameter int DW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic [7:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             bus_rvalid,
    input  logic             tx_full,
    input  logic             rx_empty,
    input  logic [DW-1:0]    rx_head,
    input  logic [NPEND-1:0] pend,
    output logic             tx_push,
    output logic [DW-1:0]    tx_push_data,
    output logic             rx_pop,
    output logic [CW-1:0]    tx_mark,
    output logic [CW-1:0]    rx_mark,
    output logic [NPEND-1:0] irq_en
);
    acc_state_e  state_q, state_d;
    logic        wr_req, rd_req;
    logic [31:0] rdata_d, rdata_q;

    assign wr_req       = bus_sel && bus_we;
    assign rd_req       = bus_sel && !bus_we;
    assign tx_push      = wr_req && (bus_addr == ADDR_TXQ);
    assign tx_push_data = bus_wdata[DW-1:0];
    assign rx_pop       = rd_req && (bus_addr == ADDR_RXQ) && !rx_empty;

    // next-state logic
    always_comb begin
        unique case (state_q)
            ACC_IDLE:  state_d = rd_req ? ACC_REPLY : ACC_IDLE;
            ACC_REPLY: state_d = rd_req ? ACC_REPLY : ACC_IDLE;
            default:   state_d = ACC_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        bus_rvalid = (state_q == ACC_REPLY);
        bus_rdata  = rdata_q;
    end

    // read mux
    always_comb begin
        rdata_d = '0;
        case (bus_addr)
            ADDR_TXQ:     rdata_d[FLAG_BIT] = tx_full;
            ADDR_RXQ: begin
                rdata_d[FLAG_BIT] = rx_empty;
                if (!rx_empty) rdata_d[DW-1:0] = rx_head;
            end
            ADDR_TXLVL:   rdata_d[CW-1:0]    = tx_mark;
            ADDR_RXLVL:   rdata_d[CW-1:0]    = rx_mark;
            ADDR_IRQEN:   rdata_d[NPEND-1:0] = irq_en;
            ADDR_IRQPEND: rdata_d[NPEND-1:0] = pend;
            default:      rdata_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            tx_mark <= '0;
            rx_mark <= '0;
            irq_en  <= '0;
        end else begin
            if (rd_req) rdata_q <= rdata_d;
            if (wr_req) begin
                case (bus_addr)
                    ADDR_TXLVL: tx_mark <= bus_wdata[CW-1:0];
                    ADDR_RXLVL: rx_mark <= bus_wdata[CW-1:0];
                    ADDR_IRQEN: irq_en  <= bus_wdata[NPEND-1:0];
                    default:    ;
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_fifo_if.sv
module spi_fifo_if
    import spi_fifo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_we,
    input  logic [7:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          bus_rvalid,
    output logic          tx_pop_valid,
    output logic [DW-1:0] tx_pop_data,
    input  logic          tx_pop_ready,
    input  logic          rx_push_valid,
    input  logic [DW-1:0] rx_push_data,
    output logic          rx_push_ready,
    output logic          irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0]    tx_cnt, rx_cnt, tx_mark, rx_mark;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic             tx_push, rx_pop;
    logic [DW-1:0]    tx_push_data, rx_head;
    logic [NPEND-1:0] pend, irq_en;

    assign tx_pop_valid  = !tx_empty;
    assign rx_push_ready = !rx_full;

    spi_fifo_buf #(.DEPTH(DEPTH), .WIDTH(DW)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push_en(tx_push), .push_data(tx_push_data),
        .pop_en(tx_pop_ready), .head(tx_pop_data),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    spi_fifo_buf #(.DEPTH(DEPTH), .WIDTH(DW)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push_en(rx_push_valid), .push_data(rx_push_data),
        .pop_en(rx_pop), .head(rx_head),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    spi_fifo_regs #(.CW(CW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .tx_full(tx_full), .rx_empty(rx_empty), .rx_head(rx_head), .pend(pend),
        .tx_push(tx_push), .tx_push_data(tx_push_data), .rx_pop(rx_pop),
        .tx_mark(tx_mark), .rx_mark(rx_mark), .irq_en(irq_en)
    );

    spi_fifo_wm #(.CW(CW)) u_wm (
        .tx_count(tx_cnt), .rx_count(rx_cnt),
        .tx_mark(tx_mark), .rx_mark(rx_mark),
        .irq_en(irq_en), .pend(pend), .irq(irq)
    );
endmodule

// File: rtl/spi_fifo_if_chk.sv
module spi_fifo_if_chk #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_we,
    input logic [7:0]    bus_addr,
    input logic [31:0]   bus_rdata,
    input logic          bus_rvalid,
    input logic          tx_pop_ready,
    input logic          rx_push_valid,
    input logic          irq,
    input logic [CW-1:0] tx_cnt,
    input logic [CW-1:0] rx_cnt,
    input logic [CW-1:0] tx_mark,
    input logic [1:0]    irq_en
);
    p_rvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we) |=> bus_rvalid);

    p_norvalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_we) |=> !bus_rvalid);

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt == CW'(DEPTH) && !tx_pop_ready) |=> (tx_cnt == CW'(DEPTH)));

    p_tx_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_cnt <= CW'(DEPTH));

    p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_we && bus_addr == 8'h4C && rx_cnt == '0 && !rx_push_valid)
        |=> (rx_cnt == '0 && bus_rdata == 32'h8000_0000));

    p_irq_tx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cnt == '0 && tx_mark != '0 && irq_en[0]) |-> irq);

    p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 2'b00) |-> !irq);
endmodule

bind spi_fifo_if spi_fifo_if_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .tx_pop_ready(tx_pop_ready), .rx_push_valid(rx_push_valid), .irq(irq),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .tx_mark(tx_mark), .irq_en(irq_en)
);

// File: tb/spi_fifo_if_bench.sv
`timescale 1ns/1ps
module spi_fifo_if_bench;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        tx_pop_valid;
    logic [7:0]  tx_pop_data;
    logic        tx_pop_ready = 1'b0;
    logic        rx_push_valid = 1'b0;
    logic [7:0]  rx_push_data = '0;
    logic        rx_push_ready;
    logic        irq;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    spi_fifo_if u_spi_fifo_if (.*);

    // entry: [47:44] requirement number, [40] read-and-compare, [39:32] addr, [31:0] data
    localparam int NV = 13;
    localparam logic [47:0] VEC [NV] = '{
        {4'd3,  4'h1, 8'h48, 32'h0000_0000},  // R3 tx not full
        {4'd5,  4'h1, 8'h4C, 32'h8000_0000},  // R5 rx empty
        {4'd7,  4'h1, 8'h74, 32'h0000_0000},  // R7/R8 thresholds 0
        {4'd10, 4'h0, 8'h50, 32'h0000_0003},
        {4'd10, 4'h1, 8'h50, 32'h0000_0003},  // R10 readback
        {4'd7,  4'h1, 8'h74, 32'h0000_0001},  // R7 0 < 3
        {4'd1,  4'h0, 8'h48, 32'h0000_00A1},
        {4'd1,  4'h0, 8'h48, 32'h0000_00A2},
        {4'd7,  4'h1, 8'h74, 32'h0000_0001},  // R7 2 < 3
        {4'd1,  4'h0, 8'h48, 32'h0000_00A3},
        {4'd7,  4'h1, 8'h74, 32'h0000_0000},  // R7 3 == 3 not pending
        {4'd10, 4'h0, 8'h54, 32'h0000_0001},
        {4'd10, 4'h1, 8'h54, 32'h0000_0001}   // R10 readback
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
        check("R10 rvalid", {31'b0, bus_rvalid}, 32'd1);
        d = bus_rdata;
    endtask

    task automatic tx_take(input logic [7:0] exp);
        @(negedge clk);
        check("R12 tx_pop_valid", {31'b0, tx_pop_valid}, 32'd1);
        check("R1 tx order", {24'b0, tx_pop_data}, {24'b0, exp});
        tx_pop_ready = 1;
        @(negedge clk);
        tx_pop_ready = 0;
    endtask

    task automatic rx_feed(input logic [7:0] b);
        @(negedge clk);
        rx_push_valid = 1; rx_push_data = b;
        @(negedge clk);
        rx_push_valid = 0;
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 tx_pop_valid", {31'b0, tx_pop_valid}, 0);
        check("R11 irq", {31'b0, irq}, 0);
        check("R11 rvalid", {31'b0, bus_rvalid}, 0);
        rst_n = 1;
        @(negedge clk);
        check("R11 rx_push_ready", {31'b0, rx_push_ready}, 1);
        check("R11 tx_pop_valid", {31'b0, tx_pop_valid}, 0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][40]) begin
                bus_rd(VEC[i][39:32], r);
                check($sformatf("R%0d vec%0d", VEC[i][47:44], i), r, VEC[i][31:0]);
            end else begin
                bus_wr(VEC[i][39:32], VEC[i][31:0]);
            end
        end
        @(negedge clk);
        check("R10 rvalid drops", {31'b0, bus_rvalid}, 0);

        // R2/R3: fill to DEPTH, then overflow
        for (int k = 0; k < DEPTH - 3; k++) bus_wr(8'h48, 32'hB0 + k);
        bus_rd(8'h48, r);
        check("R3 full flag", r, 32'h8000_0000);
        bus_wr(8'h48, 32'h0000_00EE);
        tx_take(8'hA1); tx_take(8'hA2); tx_take(8'hA3);
        for (int k = 0; k < DEPTH - 3; k++) tx_take(8'(8'hB0 + k));
        @(negedge clk);
        check("R2 dropped write absent", {31'b0, tx_pop_valid}, 0);

        // R9 interrupt masking (tx pend: 0 < 3)
        check("R9 irq masked", {31'b0, irq}, 0);
        bus_wr(8'h70, 32'h3);
        bus_rd(8'h70, r);
        check("R10 enable readback", r, 32'h3);
        check("R9 irq on", {31'b0, irq}, 1);
        bus_wr(8'h70, 32'h2);
        check("R9 irq off, rx not pending", {31'b0, irq}, 0);

        // R8 rx threshold 1
        rx_feed(8'h11);
        bus_rd(8'h74, r);
        check("R8 1 == 1 not pending", r, 32'h1);
        rx_feed(8'h22);
        bus_rd(8'h74, r);
        check("R8 2 > 1 pending", r, 32'h3);
        check("R9 irq via rx", {31'b0, irq}, 1);

        // R4/R5
        bus_rd(8'h4C, r); check("R4 first", r, 32'h0000_0011);
        bus_rd(8'h4C, r); check("R4 second", r, 32'h0000_0022);
        bus_rd(8'h4C, r); check("R5 empty", r, 32'h8000_0000);
        bus_rd(8'h4C, r); check("R5 empty again", r, 32'h8000_0000);
        rx_feed(8'h33);
        bus_rd(8'h4C, r); check("R5 no phantom pop", r, 32'h0000_0033);

        // R6 rx full
        for (int k = 0; k < DEPTH; k++) rx_feed(8'hC0 + 8'(k));
        @(negedge clk);
        check("R6 ready low", {31'b0, rx_push_ready}, 0);
        rx_feed(8'h5A);
        for (int k = 0; k < DEPTH; k++) begin
            bus_rd(8'h4C, r);
            check("R6 rx order", r, 32'hC0 + k);
        end
        bus_rd(8'h4C, r); check("R6 refused byte absent", r, 32'h8000_0000);
        check("R6 ready high", {31'b0, rx_push_ready}, 1);

        summary();
    end
endmodule